// File: doc/BRIEF.md
# Multi-cycle integer instruction sequencer

This block is a small 32-bit integer processor core that does not overlap instructions. Each instruction walks through a fixed chain of steps: fetch, decode with register read, execute or address formation, memory access or branch resolution, and register write-back. Intermediate values are held in internal working registers between steps: instruction word, next PC, two operands, extended immediate, ALU result, branch condition and load data. Each instruction class visits only the steps it needs, so instructions take different numbers of cycles.

The core has two memory ports, one for instructions and one for data. Both take a word address and return read data in the same cycle. The data port also has write data and a write strobe, and the write happens at the clock edge. A one-cycle retire pulse marks the last cycle of every instruction.

The sequencer has these states: `ST_FETCH`, `ST_DECODE`, `ST_EXEC`, `ST_MEM`, `ST_WB` and `ST_IDLE`. Every instruction leaves `ST_FETCH` for `ST_DECODE`. From `ST_DECODE`, an unknown opcode goes to `ST_IDLE` and every other opcode goes to `ST_EXEC`. From `ST_EXEC`, ALU operations go to `ST_WB` and memory and branch operations go to `ST_MEM`. From `ST_MEM`, a load goes to `ST_WB`, while a store or a branch returns to `ST_FETCH`. `ST_WB` and `ST_IDLE` always return to `ST_FETCH`.

Top module: `mc_core`

## Requirements
- R1: While rst_n is low, retire and dmem_we are 0 and the PC is RESET_PC (0), so imem_addr is 0. All registers clear to zero, and the first cycle after reset is a fetch.
- R2: Instruction fields are as follows. The opcode is bits [31:26] and the first source register is [25:21]. The second source register (or the immediate-form destination) is [20:16], and the register-form destination is [15:11]. The function code is [10:0], and the immediate is [15:0], sign-extended from bit 15.
- R3: Opcode 0x00 is register-register. It writes the result to register [15:11] and takes 4 cycles. The function codes are 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor and 0x2A signed set-less-than. Any other function code writes 0.
- R4: The immediate ops are 0x08 add, 0x0A signed set-less-than, 0x0C and, 0x0D or and 0x0E xor. Each combines rs1 with the sign-extended immediate, writes register [20:16] and takes 4 cycles.
- R5: Load word (0x23) reads the data word at byte address rs1+imm, with word address = byte address bits [ADDR_W+1:2]. It writes register [20:16] and takes 5 cycles.
- R6: Store word (0x2B) raises dmem_we for exactly one cycle, the instruction's last. In that cycle it drives address rs1+imm (word-addressed) and data from register [20:16]. It takes 4 cycles.
- R7: Branch-if-zero (0x04) and branch-if-nonzero (0x05) test rs1 and take 4 cycles. When taken, the next PC is PC+4+imm (a byte offset). Otherwise it is PC+4.
- R8: imem_addr is PC bits [ADDR_W+1:2] and holds steady until the retire cycle. Every non-branch instruction advances the PC by 4.
- R9: Register 0 always reads as zero, and writes to it have no effect.
- R10: Any other opcode retires after 3 cycles and writes no register and no memory.
- R11: retire is high only in the final cycle of each instruction, and the next cycle fetches the following instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | ADDR_W | Instruction word address |
| imem_rdata | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | ADDR_W | Data word address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Data write strobe |
| dmem_rdata | input | 32 | Data word at dmem_addr |
| retire | output | 1 | Last cycle of an instruction |

## Verification
The hardest cases are the ones where the state held between steps matters. These are a load that reads a word stored by the instruction just before it, a taken branch that skips over an instruction, and a write aimed at register 0. None of these shows up directly at the ports. A directed prefix sets up each case on purpose. The random body then draws registers from a pool of eight and data addresses from sixteen words, so read-after-write chains and store-load collisions happen often. A closing series of stores copies every register, including register 0, into memory, where the bench compares it with its own instruction-level model.

// File: rtl/mc_core_pkg.sv
package mc_core_pkg;

    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int RIDX = $clog2(NREG);

    localparam logic [5:0] OPC_RR   = 6'h00;
    localparam logic [5:0] OPC_BEQZ = 6'h04;
    localparam logic [5:0] OPC_BNEZ = 6'h05;
    localparam logic [5:0] OPC_ADDI = 6'h08;
    localparam logic [5:0] OPC_SLTI = 6'h0A;
    localparam logic [5:0] OPC_ANDI = 6'h0C;
    localparam logic [5:0] OPC_ORI  = 6'h0D;
    localparam logic [5:0] OPC_XORI = 6'h0E;
    localparam logic [5:0] OPC_LW   = 6'h23;
    localparam logic [5:0] OPC_SW   = 6'h2B;

    localparam logic [10:0] FN_ADD = 11'h020;
    localparam logic [10:0] FN_SUB = 11'h022;
    localparam logic [10:0] FN_AND = 11'h024;
    localparam logic [10:0] FN_OR  = 11'h025;
    localparam logic [10:0] FN_XOR = 11'h026;
    localparam logic [10:0] FN_SLT = 11'h02A;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB, ST_IDLE
    } state_t;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT, ALU_ZERO
    } alu_op_t;

    typedef enum logic [2:0] {
        CL_RR, CL_RI, CL_LOAD, CL_STORE, CL_BRANCH, CL_BAD
    } iclass_t;

    typedef struct packed {
        iclass_t cls;
        alu_op_t op;
        logic    inv;   // branch on non-zero
    } dec_t;

    function automatic dec_t decode_ir(input logic [XLEN-1:0] ir);
        dec_t d;
        d.cls = CL_BAD;
        d.op  = ALU_ADD;
        d.inv = 1'b0;
        case (ir[31:26])
            OPC_RR: begin
                d.cls = CL_RR;
                case (ir[10:0])
                    FN_ADD:  d.op = ALU_ADD;
                    FN_SUB:  d.op = ALU_SUB;
                    FN_AND:  d.op = ALU_AND;
                    FN_OR:   d.op = ALU_OR;
                    FN_XOR:  d.op = ALU_XOR;
                    FN_SLT:  d.op = ALU_SLT;
                    default: d.op = ALU_ZERO;
                endcase
            end
            OPC_ADDI: begin d.cls = CL_RI; d.op = ALU_ADD; end
            OPC_SLTI: begin d.cls = CL_RI; d.op = ALU_SLT; end
            OPC_ANDI: begin d.cls = CL_RI; d.op = ALU_AND; end
            OPC_ORI:  begin d.cls = CL_RI; d.op = ALU_OR;  end
            OPC_XORI: begin d.cls = CL_RI; d.op = ALU_XOR; end
            OPC_LW:   d.cls = CL_LOAD;
            OPC_SW:   d.cls = CL_STORE;
            OPC_BEQZ: d.cls = CL_BRANCH;
            OPC_BNEZ: begin d.cls = CL_BRANCH; d.inv = 1'b1; end
            default:  d.cls = CL_BAD;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int W = 32,
    parameter int N = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [$clog2(N)-1:0] ra1,
    input  logic [$clog2(N)-1:0] ra2,
    output logic [W-1:0]         rd1,
    output logic [W-1:0]         rd2,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] wa,
    input  logic [W-1:0]         wd
);

    logic [W-1:0] regs [N];

    // entry 0 is never written, so it stays at its reset value of zero (R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];

endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_core_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_t      op,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] r
);

    always_comb begin
        unique case (op)
            ALU_ADD:  r = x + y;
            ALU_SUB:  r = x - y;
            ALU_AND:  r = x & y;
            ALU_OR:   r = x | y;
            ALU_XOR:  r = x ^ y;
            ALU_SLT:  r = {{(W-1){1'b0}}, ($signed(x) < $signed(y))};
            ALU_ZERO: r = '0;
            default:  r = '0;
        endcase
    end

endmodule

// File: rtl/mc_seq.sv
module mc_seq
    import mc_core_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  iclass_t cls,
    output state_t  state,
    output logic    ld_ir,
    output logic    ld_dec,
    output logic    ld_ex,
    output logic    ld_lmd,
    output logic    mem_we,
    output logic    rf_we,
    output logic    pc_ld,
    output logic    pc_br,
    output logic    retire
);

    // state register with transitions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FETCH;
        end else begin
            unique case (state)
                ST_FETCH:  state <= ST_DECODE;
                ST_DECODE: state <= (cls == CL_BAD) ? ST_IDLE : ST_EXEC;
                ST_EXEC:   state <= (cls == CL_RR || cls == CL_RI) ? ST_WB : ST_MEM;
                ST_MEM:    state <= (cls == CL_LOAD) ? ST_WB : ST_FETCH;
                ST_WB:     state <= ST_FETCH;
                ST_IDLE:   state <= ST_FETCH;
                default:   state <= ST_FETCH;
            endcase
        end
    end

    // control outputs per state
    always_comb begin
        ld_ir  = 1'b0;
        ld_dec = 1'b0;
        ld_ex  = 1'b0;
        ld_lmd = 1'b0;
        mem_we = 1'b0;
        rf_we  = 1'b0;
        pc_ld  = 1'b0;
        pc_br  = 1'b0;
        retire = 1'b0;
        unique case (state)
            ST_FETCH:  ld_ir  = 1'b1;
            ST_DECODE: ld_dec = 1'b1;
            ST_EXEC:   ld_ex  = 1'b1;
            ST_MEM: begin
                if (cls == CL_LOAD) begin
                    ld_lmd = 1'b1;
                end else begin
                    mem_we = (cls == CL_STORE);
                    pc_br  = (cls == CL_BRANCH);
                    pc_ld  = 1'b1;
                    retire = 1'b1;
                end
            end
            ST_WB: begin
                rf_we  = 1'b1;
                pc_ld  = 1'b1;
                retire = 1'b1;
            end
            ST_IDLE: begin
                pc_ld  = 1'b1;
                retire = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_core_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] imem_addr,
    input  logic [XLEN-1:0]   imem_rdata,
    output logic [ADDR_W-1:0] dmem_addr,
    output logic [XLEN-1:0]   dmem_wdata,
    output logic              dmem_we,
    input  logic [XLEN-1:0]   dmem_rdata,
    output logic              retire
);

    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    state_t          state;
    logic            ld_ir, ld_dec, ld_ex, ld_lmd, rf_we, pc_ld, pc_br;
    logic [XLEN-1:0] pc, npc, ir, opa, opb, imm, alu_q, lmd;
    logic            cond;
    logic [XLEN-1:0] rd1, rd2, alu_x, alu_y, alu_r, wb_data;
    logic [RIDX-1:0] wb_idx;
    dec_t            dec;

    assign dec = decode_ir(ir);

    mc_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .cls    (dec.cls),
        .state  (state),
        .ld_ir  (ld_ir),
        .ld_dec (ld_dec),
        .ld_ex  (ld_ex),
        .ld_lmd (ld_lmd),
        .mem_we (dmem_we),
        .rf_we  (rf_we),
        .pc_ld  (pc_ld),
        .pc_br  (pc_br),
        .retire (retire)
    );

    assign wb_idx  = (dec.cls == CL_RR) ? ir[15:11] : ir[20:16];
    assign wb_data = (dec.cls == CL_LOAD) ? lmd : alu_q;

    mc_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (ir[25:21]),
        .ra2   (ir[20:16]),
        .rd1   (rd1),
        .rd2   (rd2),
        .we    (rf_we),
        .wa    (wb_idx),
        .wd    (wb_data)
    );

    assign alu_x = (dec.cls == CL_BRANCH) ? npc : opa;
    assign alu_y = (dec.cls == CL_RR) ? opb : imm;

    mc_alu #(.W(XLEN)) u_alu (
        .op (dec.op),
        .x  (alu_x),
        .y  (alu_y),
        .r  (alu_r)
    );

    // working registers, each loaded in its own step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc    <= RESET_PC;
            npc   <= '0;
            ir    <= '0;
            opa   <= '0;
            opb   <= '0;
            imm   <= '0;
            alu_q <= '0;
            cond  <= 1'b0;
            lmd   <= '0;
        end else begin
            if (ld_ir) begin
                ir  <= imem_rdata;
                npc <= pc + STEP;
            end
            if (ld_dec) begin
                opa <= rd1;
                opb <= rd2;
                imm <= {{(XLEN-16){ir[15]}}, ir[15:0]};
            end
            if (ld_ex) begin
                alu_q <= alu_r;
                cond  <= (opa == '0) ^ dec.inv;
            end
            if (ld_lmd) lmd <= dmem_rdata;
            if (pc_ld)  pc  <= (pc_br && cond) ? alu_q : npc;
        end
    end

    assign imem_addr  = pc[ADDR_W+1:2];
    assign dmem_addr  = alu_q[ADDR_W+1:2];
    assign dmem_wdata = opb;

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
    import mc_core_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              retire,
    input logic              dmem_we,
    input logic [ADDR_W-1:0] imem_addr,
    input state_t            state
);

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |-> (!retire && !dmem_we));

    a_r6_write_on_last_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> retire);

    a_r8_pc_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !retire |=> $stable(imem_addr));

    a_r10_idle_retires: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (retire && !dmem_we));

    a_r11_fetch_follows: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> (state == ST_FETCH));

    a_r11_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !retire ##1 !retire);

endmodule

bind mc_core mc_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .retire    (retire),
    .dmem_we   (dmem_we),
    .imem_addr (imem_addr),
    .state     (state)
);

// File: tb/mc_core_test.sv
`timescale 1ns/1ps
module mc_core_test;

    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int NRAND = 150;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [AW-1:0] imem_addr, dmem_addr;
    logic [31:0]   imem_rdata, dmem_wdata, dmem_rdata;
    logic          dmem_we, retire;

    logic [31:0] imem [DEPTH];
    logic [31:0] dmem [DEPTH];

    assign imem_rdata = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_addr];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;

    mc_core #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .dmem_rdata(dmem_rdata),
        .retire(retire)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] m_reg [32];
    logic [31:0] m_mem [DEPTH];
    logic [31:0] m_pc;
    int          end_byte;
    bit          aborted = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_rr(int rd, int rs1, int rs2, logic [10:0] fn);
        return {6'h00, 5'(rs1), 5'(rs2), 5'(rd), fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rd, int rs1, logic [15:0] im);
        return {op, 5'(rs1), 5'(rd), im};
    endfunction

    function automatic logic [31:0] sx(logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] ref_op(logic [10:0] fn, logic [31:0] x, logic [31:0] y);
        case (fn)
            11'h020: return x + y;
            11'h022: return x - y;
            11'h024: return x & y;
            11'h025: return x | y;
            11'h026: return x ^ y;
            11'h02A: return {31'b0, $signed(x) < $signed(y)};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [10:0] imm_fn(logic [5:0] op);
        case (op)
            6'h08:   return 11'h020;
            6'h0A:   return 11'h02A;
            6'h0C:   return 11'h024;
            6'h0D:   return 11'h025;
            default: return 11'h026;
        endcase
    endfunction

    task automatic set_reg(input logic [4:0] rd, input logic [31:0] v);
        if (rd != 5'd0) m_reg[rd] = v;
    endtask

    task automatic model_step(output int cyc, output bit we, output logic [AW-1:0] wa,
                              output logic [31:0] wd, output string tag);
        logic [31:0] ins, x, y, imm, npc, ea;
        bit taken;
        ins = imem[m_pc[AW+1:2]];
        x   = m_reg[ins[25:21]];
        y   = m_reg[ins[20:16]];
        imm = sx(ins[15:0]);
        npc = m_pc + 32'd4;
        ea  = x + imm;
        we  = 1'b0; wa = '0; wd = '0;
        m_pc = npc;
        case (ins[31:26])
            6'h00: begin cyc = 4; tag = "R3"; set_reg(ins[15:11], ref_op(ins[10:0], x, y)); end
            6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0E: begin
                cyc = 4; tag = "R4"; set_reg(ins[20:16], ref_op(imm_fn(ins[31:26]), x, imm));
            end
            6'h23: begin cyc = 5; tag = "R5"; set_reg(ins[20:16], m_mem[ea[AW+1:2]]); end
            6'h2B: begin
                cyc = 4; tag = "R6"; we = 1'b1; wa = ea[AW+1:2]; wd = y; m_mem[wa] = y;
            end
            6'h04, 6'h05: begin
                cyc = 4; tag = "R7";
                taken = (x == 32'h0) ^ ins[26];
                if (taken) m_pc = npc + imm;
            end
            default: begin cyc = 3; tag = "R10"; end
        endcase
    endtask

    task automatic run_one();
        int cyc, ecyc;
        bit ewe, early;
        logic [AW-1:0] ewa;
        logic [31:0] ewd, pc_now;
        string tag;
        pc_now = m_pc;
        check(imem_addr == pc_now[AW+1:2], "R7/R8", "fetch address", 32'(imem_addr), 32'(pc_now[AW+1:2]));
        check(retire == 1'b0, "R11", "retire in fetch", 32'(retire), 32'h0);
        model_step(ecyc, ewe, ewa, ewd, tag);
        cyc = 1; early = 1'b0;
        while (!retire && cyc < 10) begin
            if (dmem_we) early = 1'b1;
            @(negedge clk);
            cyc++;
        end
        check(cyc == ecyc, tag, "cycles per instruction", 32'(cyc), 32'(ecyc));
        if (cyc != ecyc) aborted = 1'b1;
        check(!early, "R6", "write before last cycle", 32'(early), 32'h0);
        check(dmem_we == ewe, (ewe ? "R6" : "R10"), "write strobe", 32'(dmem_we), 32'(ewe));
        if (ewe) begin
            check(dmem_addr == ewa, "R6", "store address", 32'(dmem_addr), 32'(ewa));
            check(dmem_wdata == ewd, "R6", "store data", dmem_wdata, ewd);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R11 watchdog: actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int idx;
        logic [10:0] fns [7];
        logic [5:0]  iops [5];
        fns  = '{11'h020, 11'h022, 11'h024, 11'h025, 11'h026, 11'h02A, 11'h7FF};
        iops = '{6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0E};
        void'($urandom(32'd2024));
        for (int i = 0; i < DEPTH; i++) begin
            imem[i]  = 32'h0;
            dmem[i]  = $urandom;
            m_mem[i] = dmem[i];
        end
        for (int i = 0; i < 32; i++) m_reg[i] = 32'h0;
        m_pc = 32'h0;

        // directed corner cases
        imem[0]  = enc_i(6'h08, 1, 0, 16'hFFFF);   // negative immediate
        imem[1]  = enc_i(6'h08, 0, 0, 16'h0005);   // write to register 0
        imem[2]  = enc_rr(2, 1, 0, 11'h020);
        imem[3]  = enc_i(6'h2B, 1, 0, 16'h0008);   // store then load same word
        imem[4]  = enc_i(6'h23, 3, 0, 16'h0008);
        imem[5]  = enc_i(6'h04, 0, 0, 16'h0004);   // taken, skips next
        imem[6]  = enc_i(6'h08, 4, 0, 16'h0077);
        imem[7]  = enc_i(6'h05, 0, 0, 16'h0004);   // not taken
        imem[8]  = 32'hFC00_0000;                  // unknown opcode
        imem[9]  = enc_rr(5, 1, 0, 11'h02A);
        imem[10] = enc_rr(6, 0, 1, 11'h022);
        imem[11] = enc_rr(2, 1, 1, 11'h7FF);       // unknown function
        idx = 12;
        for (int i = 0; i < NRAND; i++) begin
            int k;
            k = int'($urandom % 12);
            if (k < 3)
                imem[idx] = enc_rr(int'($urandom % 8), int'($urandom % 8), int'($urandom % 8),
                                   fns[$urandom % 7]);
            else if (k < 6)
                imem[idx] = enc_i(iops[$urandom % 5], int'($urandom % 8), int'($urandom % 8),
                                  16'($urandom));
            else if (k < 8)
                imem[idx] = enc_i(6'h23, int'($urandom % 8), 0, 16'(4 * ($urandom % 16)));
            else if (k < 10)
                imem[idx] = enc_i(6'h2B, int'($urandom % 8), 0, 16'(4 * ($urandom % 16)));
            else if (k < 11)
                imem[idx] = enc_i(($urandom % 2) ? 6'h05 : 6'h04, 0, int'($urandom % 8),
                                  16'(4 * ($urandom % 4)));
            else
                imem[idx] = {6'h3F, 26'($urandom)};
            idx++;
        end
        for (int i = 0; i < 3; i++) begin imem[idx] = 32'hFC00_0000; idx++; end
        for (int i = 0; i < 32; i++) begin
            imem[idx] = enc_i(6'h2B, i, 0, 16'(32'h200 + 4 * i));
            idx++;
        end
        end_byte = idx * 4;

        repeat (3) @(negedge clk);
        check(retire == 1'b0, "R1", "retire in reset", 32'(retire), 32'h0);
        check(dmem_we == 1'b0, "R1", "write in reset", 32'(dmem_we), 32'h0);
        check(imem_addr == '0, "R1", "reset PC", 32'(imem_addr), 32'h0);
        rst_n = 1'b1;

        while (m_pc < 32'(end_byte) && !aborted) run_one();

        for (int i = 0; i < 32; i++)
            check(dmem[128 + i] == m_reg[i], (i == 0) ? "R9" : "R2", "register dump",
                  dmem[128 + i], m_reg[i]);
        for (int w = 0; w < 16; w++)
            check(dmem[w] == m_mem[w], "R5", "data memory word", dmem[w], m_mem[w]);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule